// File: doc/BRIEF.md
# Key-Protected Error Record Bank

This block keeps one error record for each monitored hardware block of a larger design. Software reaches it over a 32-bit APB port. Each record holds three 64-bit registers, and each is read or written as a low and a high 32-bit word. The feature register is read-only. In the control register, one bit turns detection on and three bits are stored for interrupt logic outside the block. The status register logs what went wrong. Error reports from the safety logic arrive on a single-cycle event port. Each report carries the block index, a mechanism identifier and whether the error was corrected or uncorrected. The report is logged in the matching record, but only when that record's detection bit is set.

Writes are guarded. Every register write must come right after a write of an unlock code to a dedicated key register. A write that is not preceded by the code is dropped, and each code allows only one write. A group summary register gives one bit per record that holds a valid error. An identification register reports how many records the bank has. There are two resets. A functional reset only drops a pending unlock. A separate power-on reset is the only thing that clears the records.

Top module: `fault_record_bank`

## Requirements
- R1: After power-on reset, every control register, every status register, both group summary words and the unlock state read or behave as zero (a write without a fresh key has no effect).
- R2: The identification register at offset 0xFC8 reads the record count (44 by default) in bits 15:0, with bits 31:16 zero.
- R3: A write of 0xBE to offset 0xEA0 arms the unlock. The next write to any other offset takes effect and disarms it. A write made while disarmed is ignored. A read does not disarm. A write of any other value to 0xEA0 disarms.
- R4: Record n occupies 64 bytes at n*64. Feature low/high is at +0x00/+0x04, control at +0x08/+0x0C and status at +0x10/+0x14. Control bits 3:0 are writable (bit 0 is detection enable) and bits 31:4 read zero. Feature low reads 0x00001005 and ignores writes. Every high word reads zero.
- R5: An event for record b, with control bit 0 of that record set, sets status bit 30 (valid) and puts the mechanism ID in bits 7:0. It sets bit 29 if uncorrected, otherwise it writes 2'b10 into bits 25:24. Events for a disabled record, or for an index of 44 or more, change nothing.
- R6: An event arriving while valid is set sets bit 27 (overflow) and keeps the first mechanism ID. It also adds its own uncorrected bit or corrected field.
- R7: An unlocked write to status low clears each of bits 30, 29, 27 and 25:24 where a 1 is written. Clearing bit 30 also zeroes bits 7:0. Bits written as 0 keep their value.
- R8: Group summary offset 0xE00 holds records 0..31 and 0xE04 holds records 32..43. Bit n equals the valid bit of record n.
- R9: A functional reset disarms the unlock and leaves all records unchanged. Only power-on reset clears the records.
- R10: When a status clear and an event hit the same record in the same cycle, the clear applies first and the event is then logged against the cleared record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| func_rst_n | input | 1 | Functional reset, active low, clears only the unlock |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| ev_valid | input | 1 | Error event strobe |
| ev_blk | input | 6 | Record index of the event |
| ev_mech | input | 8 | Mechanism identifier of the event |
| ev_uncorr | input | 1 | 1 = uncorrected error, 0 = corrected |

## Verification
The bench goes after the unlock rules. It reads between the key and the write: a design that consumed the key on a read would drop the write. It follows a good key with a bad one: a design that kept the earlier arm would accept the write. It then writes a second time after one key: a design that left the key armed would let that write through. A second event on a logged record must leave the first mechanism ID in place, so a design that overwrote the ID would fail. The bench also lines a write-one-to-clear up with an event in the same cycle, where a design that applied the clear last would lose the new error. Finally it pulses the functional reset on a populated bank, where any record loss or leftover arm shows up as a wrong read.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned MECH_W = 8;
  localparam int unsigned CTRL_W = 4;

  // bit positions inside the status low word
  localparam int unsigned ST_VALID  = 30;
  localparam int unsigned ST_UNCORR = 29;
  localparam int unsigned ST_OVF    = 27;
  localparam int unsigned ST_CE_LO  = 24;
  localparam logic [1:0]  CE_CODE   = 2'b10;
  localparam logic [31:0] ST_CLR_MASK =
    (32'h1 << ST_VALID) | (32'h1 << ST_UNCORR) | (32'h1 << ST_OVF) | (32'h3 << ST_CE_LO);

  // offsets inside one 64-byte record
  localparam logic [5:0] REC_FEAT_LO = 6'h00;
  localparam logic [5:0] REC_CTRL_LO = 6'h08;
  localparam logic [5:0] REC_STAT_LO = 6'h10;

  // global offsets
  localparam logic [ADDR_W-1:0] OFF_GRP_LO = 12'hE00;
  localparam logic [ADDR_W-1:0] OFF_GRP_HI = 12'hE04;
  localparam logic [ADDR_W-1:0] OFF_KEY    = 12'hEA0;
  localparam logic [ADDR_W-1:0] OFF_ID     = 12'hFC8;

  // next status word: the clear is applied first, then a logged event
  function automatic logic [31:0] status_next(
    input logic [31:0]       cur,
    input logic              clr_en,
    input logic [31:0]       clr_bits,
    input logic              log_en,
    input logic              uncorr,
    input logic [MECH_W-1:0] mech
  );
    logic [31:0] s;
    s = cur;
    if (clr_en) begin
      s = s & ~(clr_bits & ST_CLR_MASK);
      if (clr_bits[ST_VALID]) s[MECH_W-1:0] = '0;
    end
    if (log_en) begin
      if (s[ST_VALID]) begin
        s[ST_OVF] = 1'b1;
      end else begin
        s[ST_VALID]     = 1'b1;
        s[MECH_W-1:0]   = mech;
      end
      if (uncorr) s[ST_UNCORR] = 1'b1;
      else        s[ST_CE_LO+1 -: 2] = CE_CODE;
    end
    return s;
  endfunction
endpackage

// File: rtl/frb_unlock.sv
module frb_unlock #(
  parameter logic [31:0] UNLOCK_CODE = 32'h0000_00BE
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        func_rst_n,
  input  logic        wr_stb,
  input  logic        wr_to_key,
  input  logic [31:0] wdata,
  output logic        armed,
  output logic        commit
);
  logic key_match;
  assign key_match = (wdata == UNLOCK_CODE);
  assign commit    = wr_stb && !wr_to_key && armed;

  always_ff @(posedge clk or negedge por_n or negedge func_rst_n) begin
    if (!por_n || !func_rst_n) armed <= 1'b0;
    else if (wr_stb)           armed <= wr_to_key && key_match;
  end

  // R3
  key_consumed_chk: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (wr_stb && !(wr_to_key && key_match)) |=> !armed);
  // R3
  key_arms_chk: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (wr_stb && wr_to_key && key_match) |=> armed);
endmodule

// File: rtl/frb_record.sv
module frb_record
  import frb_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              ctrl_we,
  input  logic              stat_we,
  input  logic [31:0]       wdata,
  input  logic              ev_hit,
  input  logic              ev_uncorr,
  input  logic [MECH_W-1:0] ev_mech,
  output logic [CTRL_W-1:0] ctrl,
  output logic [31:0]       status,
  output logic              valid
);
  logic log_en;
  assign log_en = ev_hit && ctrl[0];
  assign valid  = status[ST_VALID];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       ctrl <= '0;
    else if (ctrl_we) ctrl <= wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) status <= '0;
    else        status <= status_next(status, stat_we, wdata, log_en, ev_uncorr, ev_mech);
  end

  // R5
  no_log_disabled_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!ctrl[0] && !stat_we) |=> $stable(status));
  // R6
  first_id_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
    (valid && !stat_we) |=> $stable(status[MECH_W-1:0]));
  // R6
  overflow_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (valid && log_en && !stat_we) |=> status[ST_OVF]);
endmodule

// File: rtl/fault_record_bank.sv
module fault_record_bank
  import frb_pkg::*;
#(
  parameter int unsigned NREC    = 44,
  parameter int unsigned BLK_W   = 6,
  parameter logic [31:0] FEAT_LO = 32'h0000_1005,
  parameter logic [31:0] KEY     = 32'h0000_00BE
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              func_rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              ev_valid,
  input  logic [BLK_W-1:0]  ev_blk,
  input  logic [MECH_W-1:0] ev_mech,
  input  logic              ev_uncorr
);
  localparam int unsigned RIW      = ADDR_W - 6;
  localparam int unsigned REC_SPAN = NREC * 64;

  logic                       wr_stb, wr_to_key, armed, commit;
  logic [RIW-1:0]             rec_idx;
  logic [5:0]                 rec_off;
  logic                       rec_in_range;
  logic [NREC-1:0][CTRL_W-1:0] ctrl_all;
  logic [31:0]                stat_all [NREC];
  logic [NREC-1:0]            vld_all;
  logic [63:0]                grp;
  logic [31:0]                rd;

  assign wr_stb       = psel && penable && pwrite;
  assign wr_to_key    = (paddr == OFF_KEY);
  assign rec_idx      = paddr[ADDR_W-1:6];
  assign rec_off      = paddr[5:0];
  assign rec_in_range = (32'(paddr) < REC_SPAN);
  assign grp          = 64'(vld_all);

  frb_unlock #(.UNLOCK_CODE(KEY)) u_unlock (
    .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n),
    .wr_stb(wr_stb), .wr_to_key(wr_to_key), .wdata(pwdata),
    .armed(armed), .commit(commit)
  );

  for (genvar g = 0; g < NREC; g++) begin : g_rec
    logic sel;
    assign sel = commit && rec_in_range && (rec_idx == RIW'(g));
    frb_record u_rec (
      .clk(clk), .por_n(por_n),
      .ctrl_we(sel && rec_off == REC_CTRL_LO),
      .stat_we(sel && rec_off == REC_STAT_LO),
      .wdata(pwdata),
      .ev_hit(ev_valid && ev_blk == BLK_W'(g)),
      .ev_uncorr(ev_uncorr), .ev_mech(ev_mech),
      .ctrl(ctrl_all[g]), .status(stat_all[g]), .valid(vld_all[g])
    );
  end

  always_comb begin
    rd = '0;
    if (rec_in_range) begin
      case (rec_off)
        REC_FEAT_LO: rd = FEAT_LO;
        REC_CTRL_LO: rd = 32'(ctrl_all[rec_idx]);
        REC_STAT_LO: rd = stat_all[rec_idx];
        default:     rd = '0;
      endcase
    end else begin
      case (paddr)
        OFF_GRP_LO: rd = grp[31:0];
        OFF_GRP_HI: rd = grp[63:32];
        OFF_ID:     rd = {16'h0, 16'(NREC)};
        default:    rd = '0;
      endcase
    end
  end
  assign prdata = rd;

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_stb && !armed) |=> $stable(ctrl_all));
  // R9
  func_reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!func_rst_n) |=> $stable(ctrl_all));
endmodule

// File: tb/fault_record_bank_test.sv
module fault_record_bank_test;
  logic        clk = 0;
  logic        por_n = 0, func_rst_n = 1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        ev_valid = 0, ev_uncorr = 0;
  logic [5:0]  ev_blk = '0;
  logic [7:0]  ev_mech = '0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  fault_record_bank uut (
    .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .ev_valid(ev_valid), .ev_blk(ev_blk),
    .ev_mech(ev_mech), .ev_uncorr(ev_uncorr)
  );

  // monitor: compare every completed read against the scoreboard queue
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read actual=%h expected=none", prdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (prdata !== e) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, paddr, prdata, e);
        end
      end
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic unlock();
    apb_wr(12'hEA0, 32'h0000_00BE);
  endtask

  task automatic inj(input logic [5:0] b, input logic [7:0] m, input logic u);
    @(posedge clk); #1 ev_valid = 1; ev_blk = b; ev_mech = m; ev_uncorr = u;
    @(posedge clk); #1 ev_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1;
    // R1 reset state, R2 identification
    apb_rd(12'hFC8, 32'd44, "R2 id count");
    apb_rd(12'h148, 32'h0, "R1 ctrl reset");
    apb_rd(12'h150, 32'h0, "R1 status reset");
    apb_rd(12'hE00, 32'h0, "R1 group lo reset");
    apb_rd(12'hE04, 32'h0, "R1 group hi reset");
    // R4 feature register, write ignored even when unlocked
    unlock(); apb_wr(12'h0C0, 32'hFFFF_FFFF);
    apb_rd(12'h0C0, 32'h0000_1005, "R4 feature lo");
    apb_rd(12'h0C4, 32'h0, "R4 feature hi");
    // R3 locked write ignored
    apb_wr(12'h148, 32'hF);
    apb_rd(12'h148, 32'h0, "R3 write without key");
    // R3 read between key and write keeps the unlock; R4 only bits 3:0
    unlock();
    apb_rd(12'hFC8, 32'd44, "R2 id during unlock");
    apb_wr(12'h148, 32'h1F);
    apb_rd(12'h148, 32'hF, "R4 ctrl writable bits");
    apb_rd(12'h14C, 32'h0, "R4 ctrl hi");
    // R3 key consumed by one write
    apb_wr(12'h148, 32'h0);
    apb_rd(12'h148, 32'hF, "R3 key single use");
    // R3 wrong key value disarms
    unlock(); apb_wr(12'hEA0, 32'h11); apb_wr(12'h188, 32'h1);
    apb_rd(12'h188, 32'h0, "R3 wrong key");
    // R5 disabled record ignores events
    inj(6'd7, 8'h55, 1'b1);
    apb_rd(12'h1D0, 32'h0, "R5 disabled record");
    // R5 corrected log
    inj(6'd5, 8'h33, 1'b0);
    apb_rd(12'h150, 32'h4200_0033, "R5 corrected log");
    apb_rd(12'hE00, 32'h0000_0020, "R8 group lo bit5");
    // R6 overflow keeps first ID
    inj(6'd5, 8'h44, 1'b1);
    apb_rd(12'h150, 32'h6A00_0033, "R6 overflow");
    apb_rd(12'h154, 32'h0, "R4 status hi");
    // R8 high group word
    unlock(); apb_wr(12'hA08, 32'h1);
    inj(6'd40, 8'h07, 1'b1);
    apb_rd(12'hA10, 32'h6000_0007, "R5 uncorrected log");
    apb_rd(12'hE04, 32'h0000_0100, "R8 group hi bit40");
    // R5 out-of-range index ignored
    inj(6'd50, 8'h66, 1'b1);
    apb_rd(12'hE00, 32'h0000_0020, "R5 index out of range lo");
    apb_rd(12'hE04, 32'h0000_0100, "R5 index out of range hi");
    // R7 write-one-to-clear
    unlock(); apb_wr(12'h150, 32'h0800_0000);
    apb_rd(12'h150, 32'h6200_0033, "R7 clear overflow only");
    unlock(); apb_wr(12'h150, 32'h4000_0000);
    apb_rd(12'h150, 32'h2200_0000, "R7 clear valid zeroes id");
    apb_rd(12'hE00, 32'h0, "R8 group follows clear");
    unlock(); apb_wr(12'h150, 32'h2300_0000);
    apb_rd(12'h150, 32'h0, "R7 clear remaining");
    // R10 clear and event in the same cycle
    unlock();
    fork
      apb_wr(12'hA10, 32'h6000_0000);
      begin @(posedge clk); inj(6'd40, 8'h09, 1'b0); end
    join
    apb_rd(12'hA10, 32'h4200_0009, "R10 clear then log");
    // R9 functional reset: key dropped, records kept
    unlock();
    @(posedge clk); #1 func_rst_n = 0;
    @(posedge clk); #1 func_rst_n = 1;
    apb_wr(12'h188, 32'h1);
    apb_rd(12'h188, 32'h0, "R9 key dropped by functional reset");
    apb_rd(12'hA10, 32'h4200_0009, "R9 status kept");
    apb_rd(12'h148, 32'hF, "R9 ctrl kept");
    // R9 / R1 power-on reset clears records
    @(posedge clk); #1 por_n = 0;
    @(posedge clk); #1 por_n = 1;
    apb_rd(12'hA10, 32'h0, "R9 por clears status");
    apb_rd(12'h148, 32'h0, "R9 por clears ctrl");
    apb_rd(12'hE04, 32'h0, "R1 por clears group");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard R1 actual=%0d pending expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule